// File: doc/BRIEF.md
# Two-Stage System Health Watchdog

This supervisor turns stalls and fault events into escalating responses. A down-counter, reloaded periodically by software with a programmable period, runs while the timer is enabled and not halted. The first time it runs out, the block raises a management interrupt so software can recover from a hung task. If it runs out again before software reloads it, the block asserts a sticky system reset to recover from a hung machine.

Three other event sources feed the same interrupt outputs. The first is a chassis-intrusion input, which is active low. The second is a boot check that forces a reset if the processor does not fetch its first instruction within a fixed window after reset. The third is a stream of memory-error messages, each of which names the interrupt it should raise. Every interrupt output is a level that stays high until its cause is cleared.

Memory-error messages arrive on a valid/ready port. Ready is always high, so a message is taken on every clock edge where valid is high and never stalls the sender. A message that repeats a pending cause merges with it.

Top module: `sys_guard`

## Requirements
- R1: While `rst_ni` is low, `smi_o`, `nmi_o`, `serr_o`, `wdt_irq_o` and `sys_rst_o` are low and `merr_ready_o` is high.
- R2: A `reload_i` edge loads the counter with `period_i`. Each edge that has `tmr_en_i` high and `halt_i` low then counts down by one. At the first edge where the counter is already zero, the first-expiry flag is set, the counter reloads, and `smi_o` goes high. With period P, this happens P+1 edges after the reload edge.
- R3: A `reload_i` edge clears the first-expiry flag, so `smi_o` from the timer drops after that edge, and the countdown restarts.
- R4: If the counter reaches zero again while the first-expiry flag is still set, `sys_rst_o` rises P+1 edges after the first expiry. It then stays high until `rst_ni` is low, and a reload does not clear it.
- R5: While `halt_i` is high or `tmr_en_i` is low, the counter holds its value, and reload still takes effect.
- R6: With `boot_en_i` high, if `fetch_stb_i` is not seen during the BOOT_WIN edges that follow the release of reset, `sys_rst_o` rises on edge BOOT_WIN. A fetch pulse seen before then disarms the check.
- R7: `intr_n_i` passes through a two-flop synchronizer and sets a sticky intrusion status 3 edges after it goes low, provided `intr_en_i` is high. The status drives `smi_o` when `intr_sel_i` is 0 and `wdt_irq_o` when `intr_sel_i` is 1.
- R8: A message is accepted when `merr_valid_i` and `merr_en_i` are high. `merr_code_i` selects the target: 0 sets `smi_o`, 1 sets `nmi_o`, 2 sets `serr_o`, and 3 sets `wdt_irq_o`. The output is high after that same edge.
- R9: The clear bits in `clr_i` work as write-1-to-clear. Bit 0 clears the intrusion status, and bits 1 to 4 clear the memory-error status for codes 0 to 3. If a new event and its clear arrive on the same edge, the event wins.
- R10: An event source whose enable is low has no effect. This covers intrusion with `intr_en_i` low, messages with `merr_en_i` low, and the boot check with `boot_en_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous release |
| reload_i | input | 1 | Software service pulse: load the period and clear the first expiry |
| period_i | input | CNT_W | Programmed timeout period |
| tmr_en_i | input | 1 | Timer enable |
| halt_i | input | 1 | Freeze the counter |
| boot_en_i | input | 1 | Boot-fetch check enable |
| fetch_stb_i | input | 1 | Pulse when the first instruction fetch is seen |
| intr_n_i | input | 1 | Chassis intrusion, active low, asynchronous |
| intr_en_i | input | 1 | Intrusion enable |
| intr_sel_i | input | 1 | Intrusion route: 0 management interrupt, 1 watchdog interrupt |
| merr_valid_i | input | 1 | Memory-error message valid |
| merr_ready_o | output | 1 | Message ready, always high |
| merr_code_i | input | 2 | Message target code |
| merr_en_i | input | 1 | Memory-error enable |
| clr_i | input | 5 | Write-1-to-clear status bits |
| smi_o | output | 1 | Management interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| serr_o | output | 1 | System error level |
| wdt_irq_o | output | 1 | Watchdog interrupt level |
| sys_rst_o | output | 1 | System reset request, sticky |

## Verification
Each result has its own latency, counted from a clock edge:

- **Timer:** the management interrupt appears P+1 edges after the reload edge, and the reset appears P+1 edges after the first expiry.
- **Intrusion:** the status shows 3 edges after the input falls.
- **Memory-error messages:** the matching level shows after the edge that accepts the message.
- **Boot check:** a missing fetch shows as reset on edge BOOT_WIN after reset release.

The bench drives its inputs and samples the outputs at falling edges. Every check follows a counted number of ticks, so it lands on the exact cycle where the output should change, with one check just before that cycle and one on it. Randomized memory-error and clear traffic is compared cycle by cycle against a status model held in the bench.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    TGT_SMI  = 2'd0,
    TGT_NMI  = 2'd1,
    TGT_SERR = 2'd2,
    TGT_WDT  = 2'd3
  } sg_tgt_e;
  localparam int N_TGT = 4;
  localparam int TGT_W = 2;
  localparam int CLR_W = N_TGT + 1;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int  W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sg_countdown.sv
module sg_countdown #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             first_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic             first_q, trip_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= RST_CNT;
      first_q <= 1'b0;
      trip_q  <= 1'b0;
    end else if (reload_i) begin
      cnt_q   <= period_i;
      first_q <= 1'b0;
    end else if (run_i) begin
      if (at_zero) begin
        cnt_q <= period_i;
        if (first_q) trip_q  <= 1'b1;
        else         first_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = first_q;
  assign trip_o  = trip_q;
endmodule

// File: rtl/sg_boot_win.sv
module sg_boot_win #(
  parameter int BOOT_WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fetch_i,
  output logic fail_o
);
  localparam int            BW_W = $clog2(BOOT_WIN + 1);
  localparam logic [BW_W-1:0] LAST = BW_W'(BOOT_WIN - 1);

  logic [BW_W-1:0] bcnt_q;
  logic            done_q, fail_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (en_i && !done_q && !fail_q) begin
      if (fetch_i)              done_q <= 1'b1;
      else if (bcnt_q == LAST)  fail_q <= 1'b1;
      else                      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/sys_guard.sv
module sys_guard
  import sg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 1000,
  parameter int BOOT_WIN   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tmr_en_i,
  input  logic             halt_i,
  input  logic             boot_en_i,
  input  logic             fetch_stb_i,
  input  logic             intr_n_i,
  input  logic             intr_en_i,
  input  logic             intr_sel_i,
  input  logic             merr_valid_i,
  output logic             merr_ready_o,
  input  logic [1:0]       merr_code_i,
  input  logic             merr_en_i,
  input  logic [4:0]       clr_i,
  output logic             smi_o,
  output logic             nmi_o,
  output logic             serr_o,
  output logic             wdt_irq_o,
  output logic             sys_rst_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             first_w, trip_w, boot_fail_w;
  logic             intr_sync_n;
  logic             intr_st_q;
  logic [N_TGT-1:0] merr_st_q;

  sg_countdown #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload_i),
    .period_i (period_i),
    .run_i    (tmr_en_i && !halt_i),
    .cnt_o    (cnt_w),
    .first_o  (first_w),
    .trip_o   (trip_w)
  );

  sg_boot_win #(.BOOT_WIN(BOOT_WIN)) u_boot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (boot_en_i),
    .fetch_i (fetch_stb_i),
    .fail_o  (boot_fail_w)
  );

  sg_sync #(.W(1), .RST_VAL(1'b1)) u_intr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (intr_n_i),
    .q_o    (intr_sync_n)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) intr_st_q <= 1'b0;
    else         intr_st_q <= (intr_st_q && !clr_i[0]) || (intr_en_i && !intr_sync_n);
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_merr
    logic hit;
    assign hit = merr_valid_i && merr_en_i && (merr_code_i == TGT_W'(t));
    always_ff @(posedge clk_i) begin
      if (!rst_ni) merr_st_q[t] <= 1'b0;
      else         merr_st_q[t] <= (merr_st_q[t] && !clr_i[t+1]) || hit;
    end
  end

  assign merr_ready_o = 1'b1;
  assign smi_o     = first_w || (intr_st_q && !intr_sel_i) || merr_st_q[TGT_SMI];
  assign nmi_o     = merr_st_q[TGT_NMI];
  assign serr_o    = merr_st_q[TGT_SERR];
  assign wdt_irq_o = (intr_st_q && intr_sel_i) || merr_st_q[TGT_WDT];
  assign sys_rst_o = trip_w || boot_fail_w;
endmodule

// File: rtl/sys_guard_chk.sv
module sys_guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_i,
  input logic             halt_i,
  input logic [CNT_W-1:0] cnt_w,
  input logic             first_w,
  input logic             trip_w,
  input logic             merr_valid_i,
  input logic             merr_en_i,
  input logic [1:0]       merr_code_i,
  input logic             nmi_o,
  input logic             serr_o,
  input logic             sys_rst_o
);
  AST_FIRST_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_w) |-> $past(cnt_w == '0));                              // R2
  AST_RELOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !first_w);                                              // R3
  AST_TRIP_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_w) |-> $past(first_w));                                   // R4
  AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o);                                            // R4
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_w));                           // R5
  AST_MERR_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merr_valid_i && merr_en_i && merr_code_i == 2'd1) |=> nmi_o);       // R8
  AST_SERR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serr_o) |-> $past(merr_valid_i && merr_en_i));                 // R8
endmodule

bind sys_guard sys_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reload_i     (reload_i),
  .halt_i       (halt_i),
  .cnt_w        (cnt_w),
  .first_w      (first_w),
  .trip_w       (trip_w),
  .merr_valid_i (merr_valid_i),
  .merr_en_i    (merr_en_i),
  .merr_code_i  (merr_code_i),
  .nmi_o        (nmi_o),
  .serr_o       (serr_o),
  .sys_rst_o    (sys_rst_o)
);

// File: tb/sys_guard_tb.sv
module sys_guard_tb;
  localparam int CNT_W = 8;
  localparam int BOOT_WIN = 16;

  logic clk = 1'b0;
  logic rst_n, reload, tmr_en, halt, boot_en, fetch;
  logic intr_n, intr_en, intr_sel, merr_valid, merr_en;
  logic [CNT_W-1:0] period;
  logic [1:0] merr_code;
  logic [4:0] clr;
  logic merr_ready, smi, nmi, serr, wdt_irq, sys_rst;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sys_guard #(.CNT_W(CNT_W), .DEF_PERIOD(200), .BOOT_WIN(BOOT_WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .period_i(period),
    .tmr_en_i(tmr_en), .halt_i(halt), .boot_en_i(boot_en), .fetch_stb_i(fetch),
    .intr_n_i(intr_n), .intr_en_i(intr_en), .intr_sel_i(intr_sel),
    .merr_valid_i(merr_valid), .merr_ready_o(merr_ready), .merr_code_i(merr_code),
    .merr_en_i(merr_en), .clr_i(clr), .smi_o(smi), .nmi_o(nmi), .serr_o(serr),
    .wdt_irq_o(wdt_irq), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3:0] next_merr(input logic [3:0] cur, input logic v,
                                           input logic en, input logic [1:0] code,
                                           input logic [4:0] c);
    logic [3:0] hit = (v && en) ? (4'b1 << code) : 4'b0;
    return (cur & ~c[4:1]) | hit;
  endfunction

  task automatic do_reset(input bit with_fetch);
    rst_n = 1'b0; reload = 0; tmr_en = 0; halt = 0; boot_en = 1; fetch = 0;
    intr_n = 1; intr_en = 0; intr_sel = 0; merr_valid = 0; merr_en = 0;
    merr_code = 0; clr = 0; period = 8'd5;
    repeat (3) tick();
    chk("R1 smi", smi, 1'b0);
    chk("R1 nmi", nmi, 1'b0);
    chk("R1 serr", serr, 1'b0);
    chk("R1 wdt_irq", wdt_irq, 1'b0);
    chk("R1 sys_rst", sys_rst, 1'b0);
    chk("R1 ready", merr_ready, 1'b1);
    rst_n = 1'b1;
    if (with_fetch) begin
      fetch = 1'b1; tick(); fetch = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_m;
    void'($urandom(32'h5eed));
    do_reset(1);

    // R2 first expiry
    tmr_en = 1; reload = 1; tick(); reload = 0;
    repeat (5) tick(); chk("R2 smi before expiry", smi, 1'b0);
    tick(); chk("R2 smi at expiry", smi, 1'b1);
    // R3 reload clears
    reload = 1; tick(); reload = 0; chk("R3 smi cleared by reload", smi, 1'b0);
    repeat (5) tick(); chk("R3 restart no smi", smi, 1'b0);
    tick(); chk("R3 restart smi", smi, 1'b1);
    // R4 second expiry
    repeat (5) tick(); chk("R4 no reset yet", sys_rst, 1'b0);
    tick(); chk("R4 reset on second expiry", sys_rst, 1'b1);
    repeat (3) tick(); chk("R4 reset sticky", sys_rst, 1'b1);
    reload = 1; tick(); reload = 0; chk("R4 reload keeps reset", sys_rst, 1'b1);

    // R5 halt and enable freeze
    do_reset(1);
    tmr_en = 1; period = 8'd4; reload = 1; tick(); reload = 0; halt = 1;
    repeat (20) tick(); chk("R5 halted no smi", smi, 1'b0);
    halt = 0;
    repeat (4) tick(); chk("R5 after halt no smi", smi, 1'b0);
    tick(); chk("R5 after halt smi", smi, 1'b1);
    reload = 1; tmr_en = 0; tick(); reload = 0; chk("R5 reload while disabled", smi, 1'b0);
    repeat (10) tick(); chk("R5 disabled no smi", smi, 1'b0);
    tmr_en = 1;
    repeat (4) tick(); chk("R5 enabled no smi", smi, 1'b0);
    tick(); chk("R5 enabled smi", smi, 1'b1);
    tmr_en = 0; reload = 1; tick(); reload = 0;

    // R7 intrusion routed to watchdog interrupt
    intr_en = 1; intr_sel = 1; intr_n = 0;
    tick(); tick(); chk("R7 intrusion not yet", wdt_irq, 1'b0);
    tick(); chk("R7 intrusion wdt_irq", wdt_irq, 1'b1);
    chk("R7 intrusion not on smi", smi, 1'b0);
    clr = 5'b00001; tick(); clr = 0; chk("R9 set wins over clear", wdt_irq, 1'b1);
    intr_n = 1; repeat (3) tick();
    clr = 5'b00001; tick(); clr = 0; chk("R9 intrusion cleared", wdt_irq, 1'b0);
    intr_sel = 0; intr_n = 0; repeat (3) tick();
    chk("R7 intrusion smi", smi, 1'b1);
    chk("R7 intrusion no wdt_irq", wdt_irq, 1'b0);
    intr_n = 1; repeat (3) tick();
    clr = 5'b00001; tick(); clr = 0; chk("R9 intrusion smi cleared", smi, 1'b0);

    // R10 disabled sources
    intr_en = 0; intr_n = 0; repeat (6) tick();
    chk("R10 intrusion disabled smi", smi, 1'b0);
    chk("R10 intrusion disabled wdt", wdt_irq, 1'b0);
    intr_n = 1; repeat (3) tick();
    merr_en = 0; merr_valid = 1; merr_code = 2'd2; tick(); merr_valid = 0;
    chk("R10 merr disabled serr", serr, 1'b0);

    // R8 R9 random memory-error traffic
    exp_m = 4'b0;
    for (int i = 0; i < 150; i++) begin
      merr_valid = 1'($urandom % 2);
      merr_en    = (($urandom % 4) != 0);
      merr_code  = 2'($urandom % 4);
      clr        = (($urandom % 3) == 0) ? 5'($urandom % 32) : 5'b0;
      tick();
      exp_m = next_merr(exp_m, merr_valid, merr_en, merr_code, clr);
      chk("R8 smi", smi, exp_m[0]);
      chk("R8 nmi", nmi, exp_m[1]);
      chk("R8 serr", serr, exp_m[2]);
      chk("R9 wdt_irq", wdt_irq, exp_m[3]);
    end
    merr_valid = 0; clr = 0;
    // directed: clear with simultaneous new event
    merr_en = 1; merr_valid = 1; merr_code = 2'd1; clr = 5'b00100; tick();
    merr_valid = 0; clr = 0; chk("R9 merr set wins", nmi, 1'b1);
    clr = 5'b00100; tick(); clr = 0; chk("R9 merr cleared", nmi, 1'b0);

    // R6 boot fetch missing
    do_reset(0);
    repeat (BOOT_WIN - 1) tick(); chk("R6 no boot reset yet", sys_rst, 1'b0);
    tick(); chk("R6 boot reset", sys_rst, 1'b1);
    // R10 boot check disabled
    rst_n = 0; tick(); boot_en = 0; tick(); rst_n = 1;
    repeat (BOOT_WIN + 24) tick(); chk("R10 boot check disabled", sys_rst, 1'b0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule